// File: doc/BRIEF.md
# PHY Register Handshake Access Master

This block lets a simple requester read and write 16-bit registers in a PHY whose register space is not memory-mapped. The PHY is reached only through a 32-bit control word driven by this block and a status pair (an acknowledge bit and a 16-bit read value) returned by the PHY. Every access is split into phases. Each phase raises one capture or strobe bit and waits for the acknowledge to go high. It then drops that bit and waits for the acknowledge to go low before the next phase may begin.

The acknowledge is not watched on every clock. It is polled once per poll interval of `POLL_CYCLES` clocks. Each wait allows at most `MAX_POLLS` polls. A wait that never sees the expected level aborts the access with an error, and the control word returns to zero. The requester offers one access at a time through a valid/ready pair. `req_ready` is high only while the block is idle. The requester must hold `req_valid` and the request fields until a clock edge where both are high. While `req_ready` is low, `req_valid` is ignored and nothing is queued. Completion is reported by a one-cycle `rsp_done` or `rsp_err` pulse.

Top module: `phy_hs_master`

## Requirements
- R1: Control word layout: bits 15:0 carry the address or data, bit 16 is address capture, bit 17 is data capture, bit 18 is the write strobe, and bit 19 is the read strobe. Bits 31:20 are always zero, and at most one of bits 19:16 is set at any time. Every access begins with an address phase. For one cycle the control word carries only the address. It then carries the address with bit 16 set until acknowledge is seen high, then carries only the address until acknowledge is seen low.
- R2: After the address phase, a write runs a data phase of the same shape using bit 17 with the write data. It then drives bit 18 alone until acknowledge is high, then the write data alone until acknowledge is low, and then drives an all-zero control word. The full control word sequence for a write is therefore: address, address|bit16, address, data, data|bit17, data, bit18, data, 0.
- R3: After the address phase, a read drives bit 19 alone until acknowledge is high, and samples `phy_rdata` at that poll. It then drives an all-zero control word until acknowledge is low, and then completes. The sampled value appears on `rsp_rdata` together with `rsp_done`.
- R4: Acknowledge is examined only at poll instants. The first poll of a wait falls `POLL_CYCLES` clocks after the wait starts, and later polls follow every `POLL_CYCLES` clocks. A phase advances at the first poll that sees the expected level. With the acknowledge returning within one interval, a write completes 2+6·`POLL_CYCLES` clocks after acceptance and a read completes 1+4·`POLL_CYCLES` clocks after acceptance.
- R5: If the poll numbered `MAX_POLLS` in a wait still sees the wrong level, the access aborts. `rsp_err` pulses, `rsp_done` does not, and the control word is zero from then on.
- R6: `req_ready` is high exactly when the block is idle. A request offered while `req_ready` is low is ignored: it is not performed later and does not alter the access in progress.
- R7: `rsp_done` and `rsp_err` are single-cycle pulses, never high together, and exactly one of them ends each accepted access.
- R8: `rsp_rdata` holds its value from the done pulse of a read until a later read captures new data. Idle cycles and write accesses do not change it.
- R9: After reset the control word is zero, `req_ready` is high, `rsp_done` and `rsp_err` are low, and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Block idle; request is taken when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle pulse: access finished normally |
| rsp_err | output | 1 | One-cycle pulse: access aborted on acknowledge timeout |
| rsp_rdata | output | 16 | Data from the last completed read |
| phy_ctrl | output | 32 | Control word toward the PHY |
| phy_ack | input | 1 | Acknowledge from the PHY status word |
| phy_rdata | input | 16 | Read value from the PHY status word |

## Verification
A PHY model acknowledges after a settable delay. Writes and reads are run against it with an acknowledge delay shorter than one poll interval, and their control word histories and completion times are compared with the expected phase sequences. A second delay, longer than one interval, forces every wait to take two polls, so a sequencer that reads the acknowledge every clock can be told apart from one that reads it only at poll instants. An acknowledge stuck low and an acknowledge stuck high make the abort fire in the capture wait and in the release wait, with distinct completion times. A request offered mid-access at a different address must leave no trace in a later readback.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

  localparam int FIELD_W      = 16;
  localparam int CTRL_W       = 32;
  localparam int CAP_ADDR_BIT = 16;
  localparam int CAP_DATA_BIT = 17;
  localparam int WR_STB_BIT   = 18;
  localparam int RD_STB_BIT   = 19;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_SET, ST_A_CAP, ST_A_REL,
    ST_D_SET, ST_D_CAP, ST_D_REL,
    ST_W_STB, ST_W_REL,
    ST_R_STB, ST_R_REL
  } seq_state_e;

  // states that sit on the acknowledge and poll it
  function automatic logic is_wait(seq_state_e s);
    return s inside {ST_A_CAP, ST_A_REL, ST_D_CAP, ST_D_REL,
                     ST_W_STB, ST_W_REL, ST_R_STB, ST_R_REL};
  endfunction

  // level of acknowledge a waiting state needs before it may advance
  function automatic logic want_ack(seq_state_e s);
    return s inside {ST_A_CAP, ST_D_CAP, ST_W_STB, ST_R_STB};
  endfunction

  function automatic seq_state_e step_after(seq_state_e s, logic wr);
    case (s)
      ST_A_SET: return ST_A_CAP;
      ST_A_CAP: return ST_A_REL;
      ST_A_REL: return wr ? ST_D_SET : ST_R_STB;
      ST_D_SET: return ST_D_CAP;
      ST_D_CAP: return ST_D_REL;
      ST_D_REL: return ST_W_STB;
      ST_W_STB: return ST_W_REL;
      ST_R_STB: return ST_R_REL;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/phy_hs_poll_timer.sv
module phy_hs_poll_timer #(
  parameter int POLL_CYCLES = 100,
  parameter int MAX_POLLS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic poll,
  output logic last
);
  localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [TW-1:0] TICK_END = TW'(POLL_CYCLES - 1);
  localparam logic [PW-1:0] POLL_END = PW'(MAX_POLLS - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] cnt_q;

  assign poll = (tick_q == TICK_END);
  assign last = (cnt_q == POLL_END);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tick_q <= '0;
      cnt_q  <= '0;
    end else if (poll) begin
      tick_q <= '0;
      if (!last) cnt_q <= cnt_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/phy_hs_ctrl_enc.sv
module phy_hs_ctrl_enc
  import phy_hs_pkg::*;
(
  input  seq_state_e          state,
  input  logic [FIELD_W-1:0]  addr,
  input  logic [FIELD_W-1:0]  data,
  output logic [CTRL_W-1:0]   ctrl
);
  always_comb begin
    ctrl = '0;
    case (state)
      ST_A_SET, ST_A_REL: ctrl[FIELD_W-1:0] = addr;
      ST_A_CAP: begin
        ctrl[FIELD_W-1:0]  = addr;
        ctrl[CAP_ADDR_BIT] = 1'b1;
      end
      ST_D_SET, ST_D_REL, ST_W_REL: ctrl[FIELD_W-1:0] = data;
      ST_D_CAP: begin
        ctrl[FIELD_W-1:0]  = data;
        ctrl[CAP_DATA_BIT] = 1'b1;
      end
      ST_W_STB: ctrl[WR_STB_BIT] = 1'b1;
      ST_R_STB: ctrl[RD_STB_BIT] = 1'b1;
      default:  ctrl = '0;
    endcase
  end
endmodule

// File: rtl/phy_hs_result.sv
module phy_hs_result #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fin_ok,
  input  logic         fin_err,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  output logic         done,
  output logic         err,
  output logic [W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      done <= fin_ok;
      err  <= fin_err;
      if (cap_en) rdata <= cap_val;
    end
  end
endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
  import phy_hs_pkg::*;
#(
  parameter int POLL_CYCLES = 100,
  parameter int MAX_POLLS   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [FIELD_W-1:0]  req_addr,
  input  logic [FIELD_W-1:0]  req_wdata,
  output logic                rsp_done,
  output logic                rsp_err,
  output logic [FIELD_W-1:0]  rsp_rdata,
  output logic [CTRL_W-1:0]   phy_ctrl,
  input  logic                phy_ack,
  input  logic [FIELD_W-1:0]  phy_rdata
);
  seq_state_e         state_q, state_d;
  logic [FIELD_W-1:0] addr_q, data_q;
  logic               wr_q;
  logic               accept;
  logic               poll, last, clr;
  logic               fin_ok, fin_err, cap_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    cap_en  = 1'b0;
    if (is_wait(state_q)) begin
      if (poll) begin
        if (phy_ack == want_ack(state_q)) begin
          state_d = step_after(state_q, wr_q);
          cap_en  = (state_q == ST_R_STB);
          fin_ok  = (step_after(state_q, wr_q) == ST_IDLE);
        end else if (last) begin
          state_d = ST_IDLE;
          fin_err = 1'b1;
        end
      end
    end else if (state_q == ST_IDLE) begin
      if (accept) state_d = ST_A_SET;
    end else begin
      state_d = step_after(state_q, wr_q);
    end
  end

  // timer restarts on every phase change and stays cleared outside waits
  assign clr = (state_d != state_q) || !is_wait(state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_wdata;
        wr_q   <= req_write;
      end
    end
  end

  phy_hs_poll_timer #(
    .POLL_CYCLES(POLL_CYCLES),
    .MAX_POLLS  (MAX_POLLS)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .poll (poll),
    .last (last)
  );

  phy_hs_ctrl_enc u_enc (
    .state(state_q),
    .addr (addr_q),
    .data (data_q),
    .ctrl (phy_ctrl)
  );

  phy_hs_result #(.W(FIELD_W)) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .fin_ok (fin_ok),
    .fin_err(fin_err),
    .cap_en (cap_en),
    .cap_val(phy_rdata),
    .done   (rsp_done),
    .err    (rsp_err),
    .rdata  (rsp_rdata)
  );
endmodule

// File: rtl/phy_hs_master_chk.sv
module phy_hs_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic [15:0] rsp_rdata,
  input logic [31:0] phy_ctrl
);
  // R1: at most one capture/strobe bit, upper bits never used
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[19:16]) && (phy_ctrl[31:20] == 12'h000));

  // R5: an abort leaves the control word at zero
  a_r5_abort_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (phy_ctrl == 32'h0));

  // R6: while idle the PHY sees no activity
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (phy_ctrl == 32'h0));

  // R7: completion pulses last one cycle and never coincide
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> !rsp_err);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_err));

  // R7: a completion pulse is seen only when the block is back to idle
  a_r7_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_err) |-> req_ready);

  // R8: idle with no request keeps the read data
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(rsp_rdata));
endmodule

bind phy_hs_master phy_hs_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .phy_ctrl (phy_ctrl)
);

// File: tb/phy_hs_master_tb.sv
module phy_hs_master_tb;
  localparam int P = 5;
  localparam int M = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [31:0] phy_ctrl;
  logic        phy_ack;
  logic [15:0] phy_rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  phy_hs_master #(.POLL_CYCLES(P), .MAX_POLLS(M)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .phy_ctrl(phy_ctrl), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  // ---------------- PHY model ----------------
  int          ack_mode = 0;   // 0 normal, 1 stuck low, 2 stuck high
  int          ack_tap  = 2;   // ack follows strobes after ack_tap+1 edges
  logic [15:0] sr;
  logic [15:0] lat_addr, lat_data;
  logic [15:0] mem [16];

  assign phy_ack = (ack_mode == 1) ? 1'b0 : (ack_mode == 2) ? 1'b1 : sr[ack_tap];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= '0;
      lat_addr  <= '0;
      lat_data  <= '0;
      phy_rdata <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'(i * 16'h1111);
    end else begin
      sr <= {sr[14:0], |phy_ctrl[19:16]};
      if (phy_ctrl[16]) lat_addr <= phy_ctrl[15:0];
      if (phy_ctrl[17]) lat_data <= phy_ctrl[15:0];
      if (phy_ctrl[18]) mem[lat_addr[3:0]] <= lat_data;
      if (phy_ctrl[19]) phy_rdata <= mem[lat_addr[3:0]];
    end
  end

  // ---------------- control word history ----------------
  logic        log_clr = 1'b1;
  logic [31:0] prev_ctrl;
  logic [31:0] hist [16];
  int          hist_n;

  always_ff @(posedge clk) begin
    if (log_clr) begin
      prev_ctrl <= '0;
      hist_n    <= 0;
    end else if (phy_ctrl != prev_ctrl) begin
      prev_ctrl <= phy_ctrl;
      if (hist_n < 16) hist[hist_n] <= phy_ctrl;
      hist_n <= hist_n + 1;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // runs one access; optionally offers a second request while busy
  task automatic run_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                            input bit intrude,
                            output bit got_done, output bit got_err, output int cyc);
    @(negedge clk);
    log_clr   = 1'b0;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    got_done = 0;
    got_err = 0;
    while (cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc == 5) begin
        chk(req_ready == 1'b0, "R6", "ready while busy", req_ready, 0);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 16'h0006;
        req_wdata = 16'h2222;
      end else if (intrude && cyc == 6) begin
        req_valid = 1'b0;
      end
      if (rsp_done || rsp_err) begin
        got_done = rsp_done;
        got_err  = rsp_err;
        break;
      end
    end
    @(negedge clk);
    chk(!rsp_done && !rsp_err, "R7", "pulse width", {rsp_done, rsp_err}, 0);
    log_clr = 1'b1;
  endtask

  task automatic t_reset;
    chk(phy_ctrl == 0, "R9", "ctrl after reset", phy_ctrl, 0);
    chk(req_ready == 1, "R9", "ready after reset", req_ready, 1);
    chk(!rsp_done && !rsp_err, "R9", "done/err after reset", {rsp_done, rsp_err}, 0);
    chk(rsp_rdata == 0, "R9", "rdata after reset", rsp_rdata, 0);
  endtask

  task automatic t_write_seq;
    bit dn, er;
    int c;
    logic [31:0] exp [9];
    exp = '{32'h0003, 32'h1_0003, 32'h0003, 32'hA5C3, 32'h2_A5C3, 32'hA5C3,
            32'h4_0000, 32'hA5C3, 32'h0};
    run_access(1, 16'h0003, 16'hA5C3, 0, dn, er, c);
    chk(dn && !er, "R7", "write ends with done", {dn, er}, 2'b10);
    chk(c == 2 + 6 * P, "R4", "write duration", c, 2 + 6 * P);
    chk(hist_n == 9, "R2", "write ctrl change count", hist_n, 9);
    for (int i = 0; i < 9; i++) begin
      if (i < 3)
        chk(hist[i] == exp[i], "R1", "write address phase word", hist[i], exp[i]);
      else
        chk(hist[i] == exp[i], "R2", "write data/strobe word", hist[i], exp[i]);
    end
  endtask

  task automatic t_read_seq;
    bit dn, er;
    int c;
    logic [31:0] exp [5];
    exp = '{32'h0003, 32'h1_0003, 32'h0003, 32'h8_0000, 32'h0};
    run_access(0, 16'h0003, 16'h0000, 0, dn, er, c);
    chk(dn && !er, "R7", "read ends with done", {dn, er}, 2'b10);
    chk(c == 1 + 4 * P, "R4", "read duration", c, 1 + 4 * P);
    chk(rsp_rdata == 16'hA5C3, "R3", "read data", rsp_rdata, 16'hA5C3);
    chk(hist_n == 5, "R3", "read ctrl change count", hist_n, 5);
    for (int i = 0; i < 5; i++)
      chk(hist[i] == exp[i], "R3", "read ctrl word", hist[i], exp[i]);
  endtask

  task automatic t_slow_ack;
    bit dn, er;
    int c;
    ack_tap = 7;  // ack after 8 edges: first poll misses, second hits
    run_access(1, 16'h0009, 16'h5A5A, 0, dn, er, c);
    chk(dn && !er, "R4", "slow write completes", {dn, er}, 2'b10);
    chk(c == 2 + 6 * 2 * P, "R4", "slow write duration", c, 2 + 12 * P);
    run_access(0, 16'h0009, 16'h0000, 0, dn, er, c);
    chk(c == 1 + 4 * 2 * P, "R4", "slow read duration", c, 1 + 8 * P);
    chk(rsp_rdata == 16'h5A5A, "R3", "slow read data", rsp_rdata, 16'h5A5A);
    ack_tap = 2;
  endtask

  task automatic t_timeout_low;
    bit dn, er;
    int c;
    ack_mode = 1;
    run_access(1, 16'h0004, 16'h7777, 0, dn, er, c);
    chk(er && !dn, "R5", "stuck-low abort", {dn, er}, 2'b01);
    chk(c == 1 + M * P, "R5", "stuck-low abort time", c, 1 + M * P);
    chk(phy_ctrl == 0, "R5", "ctrl after abort", phy_ctrl, 0);
    chk(req_ready == 1, "R6", "ready after abort", req_ready, 1);
    ack_mode = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_timeout_high;
    bit dn, er;
    int c;
    ack_mode = 2;
    run_access(0, 16'h0004, 16'h0000, 0, dn, er, c);
    chk(er && !dn, "R5", "stuck-high abort", {dn, er}, 2'b01);
    chk(c == 1 + P + M * P, "R5", "stuck-high abort time", c, 1 + P + M * P);
    chk(phy_ctrl == 0, "R5", "ctrl after release abort", phy_ctrl, 0);
    ack_mode = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    bit dn, er;
    int c;
    run_access(1, 16'h0005, 16'h1234, 1, dn, er, c);
    chk(dn && !er, "R6", "intruded write completes", {dn, er}, 2'b10);
    chk(hist_n == 9, "R6", "single sequence on PHY", hist_n, 9);
    repeat (P * 4) @(negedge clk);
    chk(req_ready == 1 && phy_ctrl == 0, "R6", "no deferred access", phy_ctrl, 0);
    run_access(0, 16'h0006, 16'h0000, 0, dn, er, c);
    chk(rsp_rdata == 16'h6666, "R6", "ignored write left reg 6", rsp_rdata, 16'h6666);
    run_access(0, 16'h0005, 16'h0000, 0, dn, er, c);
    chk(rsp_rdata == 16'h1234, "R6", "real write kept", rsp_rdata, 16'h1234);
  endtask

  task automatic t_hold;
    bit dn, er;
    int c;
    logic [15:0] keep;
    keep = rsp_rdata;
    repeat (25) @(negedge clk);
    chk(rsp_rdata == keep, "R8", "rdata over idle", rsp_rdata, keep);
    run_access(1, 16'h0002, 16'hBEEF, 0, dn, er, c);
    chk(rsp_rdata == keep, "R8", "rdata across write", rsp_rdata, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_seq();
    t_read_seq();
    t_slow_ack();
    t_timeout_low();
    t_timeout_high();
    t_busy_ignore();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule